// File: doc/BRIEF.md
# Dual-Window Bus Target with Delayed Reads

This block is the target side of a simplified 32-bit multiplexed address/data bus with PCI-style handshakes. It claims memory-class cycles that fall into one of two address windows. One window reaches a local memory through a fire-and-forget write strobe and a request/acknowledge read port. The other window reaches a bank of control registers through a write strobe and a combinational read-data input. Each data phase is checked against the access-width rule of its window using the active-low byte enables. An access that breaks the rule still completes normally. Its write data is dropped and its read data is all zeros. The target never signals target abort.

Writes to either window and reads from the register window complete with zero wait states and may burst across any number of data phases. Reads from local memory are slow, so they run as delayed transactions. The first attempt is terminated with retry and is latched into one of two slots. A fetch engine then fills the slot from local memory. A later retry that repeats the same address, command and byte enables receives the data with disconnect-with-data, and that frees the slot.

Top module: `pci_tgt_top`

## Requirements
- R1: A cycle is claimed only if it carries a memory command (read 0110, 1100 or 1110, write 0111 or 1111) and its address falls inside either window. devsel_no is low from the cycle after the address phase until the transaction ends. Other commands and other addresses leave devsel_no, trdy_no and stop_no high.
- R2: For a memory-window write, every data phase whose enables are full (cbe_ni 0000) or one 16-bit half (1100 low half, 0011 high half) gives exactly one mem_wr_o pulse. That pulse carries the data and a dword address that starts at the address phase and steps by one per phase. trdy_no is low in every phase, so bursts run with no wait state.
- R3: A register-window write gives a reg_wr_o pulse only when cbe_ni is 0000. Any other enable pattern completes with trdy_no low and no strobe.
- R4: Register-window reads with cbe_ni 0000, 1100 or 0011 return reg_rd_data_i for the current dword address in each phase, with no wait state. Any other pattern returns zero.
- R5: The first attempt of a legal memory-window read that matches no slot while a slot is free is terminated with retry (stop_no low, trdy_no high). It is latched, and exactly one local fetch follows.
- R6: A retried read whose address, command and byte enables all equal a filled slot receives the fetched word with trdy_no and stop_no low together, and the slot is freed. A read that differs in any one of the three does not receive that word.
- R7: Two reads can be outstanding at once. While both slots are occupied, a new non-matching read is retried and is not latched: it causes no fetch until it is repeated after a slot is freed.
- R8: A memory-window read with illegal enables (a single byte, three bytes, or none) completes at once with zero data and disconnect-with-data, and no fetch.
- R9: stop_no is never low while devsel_no is high (no target abort).
- R10: Once mem_rd_req_o is raised, it and mem_rd_addr_o hold steady until mem_rd_ack_i is seen.
- R11: After reset, devsel_no, trdy_no and stop_no are high, and ad_oe_o, mem_wr_o, reg_wr_o and mem_rd_req_o are low.
- R12: Repeating a read that is latched but not yet filled gets retry again and starts no second fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | Initiator cycle frame, active low |
| irdy_ni | input | 1 | Initiator ready, active low |
| ad_i | input | 32 | Address/data from the bus |
| cbe_ni | input | 4 | Command in address phase, byte enables (active low) in data phases |
| ad_o | output | 32 | Read data driven to the bus |
| ad_oe_o | output | 1 | Output enable for ad_o |
| devsel_no | output | 1 | Device select, active low |
| trdy_no | output | 1 | Target ready, active low |
| stop_no | output | 1 | Target stop request, active low |
| mem_wr_o | output | 1 | Local memory write strobe |
| mem_wr_addr_o | output | MEM_AW-2 | Local memory write dword address |
| mem_wr_data_o | output | 32 | Local memory write data |
| mem_wr_be_o | output | 4 | Local memory write byte enables, active high |
| mem_rd_req_o | output | 1 | Local memory read request |
| mem_rd_addr_o | output | MEM_AW-2 | Local memory read dword address |
| mem_rd_ack_i | input | 1 | Local memory read acknowledge |
| mem_rd_data_i | input | 32 | Local memory read data, valid with the acknowledge |
| reg_wr_o | output | 1 | Register write strobe |
| reg_addr_o | output | REG_AW-2 | Register dword address for reads and writes |
| reg_wr_data_o | output | 32 | Register write data |
| reg_rd_data_i | input | 32 | Register read data for reg_addr_o |

## Verification
The hardest state to reach is the one where both delayed slots are taken and a third, distinct read arrives. In that state the block must retry the read without latching it. Meanwhile one slot still holds an unfilled fetch and another retry of that same read must not start a second fetch. The bench gets there by making its local memory model withhold the acknowledge. It then issues reads to three addresses in turn and releases the acknowledge. Only after that does it check the fetch count and the order of delivery. Slot matching is tested by replaying one address with a changed command and then with changed byte enables.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [2:0] {ST_IDLE, ST_WR, ST_RD, ST_MRD, ST_STOP} tgt_st_e;
  typedef enum logic [1:0] {WIN_NONE, WIN_MEM, WIN_REG} win_e;

  localparam logic [3:0] CMD_MRD = 4'b0110;
  localparam logic [3:0] CMD_MWR = 4'b0111;
  localparam logic [3:0] CMD_MRM = 4'b1100;
  localparam logic [3:0] CMD_MRL = 4'b1110;
  localparam logic [3:0] CMD_MWI = 4'b1111;

  typedef struct packed {
    logic        vld;
    logic        done;
    logic [3:0]  cmd;
    logic [3:0]  be_n;
    logic [29:0] dw;
    logic [31:0] data;
  } dly_slot_t;

  function automatic logic is_rd_cmd(logic [3:0] c);
    return (c == CMD_MRD) || (c == CMD_MRM) || (c == CMD_MRL);
  endfunction

  function automatic logic is_wr_cmd(logic [3:0] c);
    return (c == CMD_MWR) || (c == CMD_MWI);
  endfunction

  // register writes need all four lanes; everything else also allows one half
  function automatic logic width_ok(win_e w, logic wr, logic [3:0] be_n);
    logic [3:0] en;
    logic full, half;
    en   = ~be_n;
    full = (en == 4'b1111);
    half = (en == 4'b0011) || (en == 4'b1100);
    if (w == WIN_REG && wr) return full;
    return full || half;
  endfunction

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter logic [31:0] MEM_BASE = 32'h1000_0000,
  parameter int          MEM_AW   = 12,
  parameter logic [31:0] REG_BASE = 32'h2000_0000,
  parameter int          REG_AW   = 8
) (
  input  logic [31:2] addr_i,
  input  logic [3:0]  cmd_i,
  output win_e        win_o,
  output logic        wr_o,
  output logic [29:0] dw_o
);

  localparam int MEM_TAG = 32 - MEM_AW;
  localparam int REG_TAG = 32 - REG_AW;

  logic mem_hit, reg_hit, cmd_ok;

  assign mem_hit = (addr_i[31:MEM_AW] == MEM_BASE[31:MEM_AW]);
  assign reg_hit = (addr_i[31:REG_AW] == REG_BASE[31:REG_AW]);
  assign cmd_ok  = is_rd_cmd(cmd_i) || is_wr_cmd(cmd_i);
  assign wr_o    = is_wr_cmd(cmd_i);
  assign dw_o    = addr_i;

  always_comb begin
    win_o = WIN_NONE;
    if (cmd_ok && MEM_TAG > 0 && mem_hit)      win_o = WIN_MEM;
    else if (cmd_ok && REG_TAG > 0 && reg_hit) win_o = WIN_REG;
  end

endmodule

// File: rtl/pci_tgt_dly.sv
module pci_tgt_dly
  import pci_tgt_pkg::*;
#(
  parameter int N_SLOT = 2,
  parameter int AW     = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic [3:0]    cmd_i,
  input  logic [3:0]    be_n_i,
  input  logic [29:0]   dw_i,
  output logic          ready_o,
  output logic [31:0]   data_o,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  input  logic          ack_i,
  input  logic [31:0]   rdata_i
);

  localparam int IW = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;

  dly_slot_t          slot_q [N_SLOT];
  logic [N_SLOT-1:0]  match, vld_vec;
  logic               hit, any_free, pend_any;
  logic [IW-1:0]      new_idx, pend_idx, cur_q;
  logic               busy_q;

  always_comb begin
    hit      = 1'b0;
    ready_o  = 1'b0;
    data_o   = '0;
    any_free = 1'b0;
    new_idx  = '0;
    pend_any = 1'b0;
    pend_idx = '0;
    for (int i = 0; i < N_SLOT; i++) begin
      vld_vec[i] = slot_q[i].vld;
      match[i]   = slot_q[i].vld && slot_q[i].cmd == cmd_i &&
                   slot_q[i].be_n == be_n_i && slot_q[i].dw == dw_i;
      hit        = hit | match[i];
      if (match[i] && slot_q[i].done) begin
        ready_o = 1'b1;
        data_o  = data_o | slot_q[i].data;
      end
    end
    for (int i = N_SLOT - 1; i >= 0; i--) begin
      if (!slot_q[i].vld) begin
        any_free = 1'b1;
        new_idx  = IW'(i);
      end
      if (slot_q[i].vld && !slot_q[i].done) begin
        pend_any = 1'b1;
        pend_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_SLOT; i++) slot_q[i] <= '0;
      busy_q <= 1'b0;
      cur_q  <= '0;
    end else begin
      for (int i = 0; i < N_SLOT; i++) begin
        if (take_i && match[i] && slot_q[i].done) slot_q[i].vld <= 1'b0;
        if (take_i && !hit && any_free && new_idx == IW'(i))
          slot_q[i] <= '{vld: 1'b1, done: 1'b0, cmd: cmd_i, be_n: be_n_i, dw: dw_i, data: '0};
        if (busy_q && ack_i && cur_q == IW'(i)) begin
          slot_q[i].data <= rdata_i;
          slot_q[i].done <= 1'b1;
        end
      end
      if (busy_q && ack_i) busy_q <= 1'b0;
      else if (!busy_q && pend_any) begin
        busy_q <= 1'b1;
        cur_q  <= pend_idx;
      end
    end
  end

  assign req_o  = busy_q;
  assign addr_o = slot_q[cur_q].dw[AW-1:0];

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(addr_o)); // R10
  AST_FULL_NO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !hit && (&vld_vec) |=> $stable(vld_vec)); // R7
  AST_DELIVER_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && ready_o |=> $countones(vld_vec) == $countones($past(vld_vec)) - 1); // R6

endmodule

// File: rtl/pci_tgt_top.sv
module pci_tgt_top
  import pci_tgt_pkg::*;
#(
  parameter logic [31:0] MEM_BASE = 32'h1000_0000,
  parameter int          MEM_AW   = 12,
  parameter logic [31:0] REG_BASE = 32'h2000_0000,
  parameter int          REG_AW   = 8,
  parameter int          N_SLOT   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic              irdy_ni,
  input  logic [31:0]       ad_i,
  input  logic [3:0]        cbe_ni,
  output logic [31:0]       ad_o,
  output logic              ad_oe_o,
  output logic              devsel_no,
  output logic              trdy_no,
  output logic              stop_no,
  output logic              mem_wr_o,
  output logic [MEM_AW-3:0] mem_wr_addr_o,
  output logic [31:0]       mem_wr_data_o,
  output logic [3:0]        mem_wr_be_o,
  output logic              mem_rd_req_o,
  output logic [MEM_AW-3:0] mem_rd_addr_o,
  input  logic              mem_rd_ack_i,
  input  logic [31:0]       mem_rd_data_i,
  output logic              reg_wr_o,
  output logic [REG_AW-3:0] reg_addr_o,
  output logic [31:0]       reg_wr_data_o,
  input  logic [31:0]       reg_rd_data_i
);

  localparam int MEM_DW = MEM_AW - 2;
  localparam int REG_DW = REG_AW - 2;

  tgt_st_e     st_q;
  win_e        win_q, dec_win;
  logic [3:0]  cmd_q;
  logic [29:0] dw_q, dec_dw;
  logic        frame_q, dec_wr;
  logic        start, phase, legal, take, dly_ready;
  logic [31:0] dly_data;

  pci_tgt_decode #(
    .MEM_BASE(MEM_BASE), .MEM_AW(MEM_AW), .REG_BASE(REG_BASE), .REG_AW(REG_AW)
  ) u_dec (
    .addr_i (ad_i[31:2]),
    .cmd_i  (cbe_ni),
    .win_o  (dec_win),
    .wr_o   (dec_wr),
    .dw_o   (dec_dw)
  );

  assign start = frame_q && !frame_ni;
  assign phase = !irdy_ni;
  assign legal = width_ok(win_q, is_wr_cmd(cmd_q), cbe_ni);
  assign take  = (st_q == ST_MRD) && phase && legal;

  pci_tgt_dly #(.N_SLOT(N_SLOT), .AW(MEM_DW)) u_dly (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .cmd_i   (cmd_q),
    .be_n_i  (cbe_ni),
    .dw_i    (dw_q),
    .ready_o (dly_ready),
    .data_o  (dly_data),
    .req_o   (mem_rd_req_o),
    .addr_o  (mem_rd_addr_o),
    .ack_i   (mem_rd_ack_i),
    .rdata_i (mem_rd_data_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      win_q   <= WIN_NONE;
      cmd_q   <= '0;
      dw_q    <= '0;
      frame_q <= 1'b1;
    end else begin
      frame_q <= frame_ni;
      unique case (st_q)
        ST_IDLE: if (start && dec_win != WIN_NONE) begin
          win_q <= dec_win;
          cmd_q <= cbe_ni;
          dw_q  <= dec_dw;
          if (dec_wr)                 st_q <= ST_WR;
          else if (dec_win == WIN_MEM) st_q <= ST_MRD;
          else                        st_q <= ST_RD;
        end
        ST_WR, ST_RD: if (phase) begin
          dw_q <= dw_q + 30'd1;
          if (frame_ni) st_q <= ST_IDLE;
        end
        ST_MRD:  if (phase) st_q <= frame_ni ? ST_IDLE : ST_STOP;
        ST_STOP: if (phase && frame_ni) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // bus-side outputs follow state and the live enables so data phases take no wait state
  always_comb begin
    devsel_no = (st_q == ST_IDLE);
    trdy_no   = 1'b1;
    stop_no   = 1'b1;
    ad_oe_o   = 1'b0;
    ad_o      = '0;
    unique case (st_q)
      ST_WR: trdy_no = 1'b0;
      ST_RD: begin
        trdy_no = 1'b0;
        ad_oe_o = 1'b1;
        ad_o    = legal ? reg_rd_data_i : '0;
      end
      ST_MRD: begin
        stop_no = 1'b0;
        ad_oe_o = 1'b1;
        trdy_no = legal && !dly_ready;
        ad_o    = legal ? dly_data : '0;
      end
      ST_STOP: stop_no = 1'b0;
      default: ;
    endcase
  end

  assign mem_wr_o      = (st_q == ST_WR) && (win_q == WIN_MEM) && phase && legal;
  assign reg_wr_o      = (st_q == ST_WR) && (win_q == WIN_REG) && phase && legal;
  assign mem_wr_addr_o = dw_q[MEM_DW-1:0];
  assign mem_wr_data_o = ad_i;
  assign mem_wr_be_o   = ~cbe_ni;
  assign reg_addr_o    = dw_q[REG_DW-1:0];
  assign reg_wr_data_o = ad_i;

  AST_NO_TGT_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_no |-> !devsel_no); // R9
  AST_TRDY_CLAIMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trdy_no |-> !devsel_no); // R1
  AST_REG_WR_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> cbe_ni == 4'b0000); // R3
  AST_MEM_WR_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (cbe_ni == 4'b0000 || cbe_ni == 4'b1100 || cbe_ni == 4'b0011)); // R2
  AST_DISC_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trdy_no && !stop_no |-> ad_oe_o); // R6

endmodule

// File: tb/pci_tgt_top_bench.sv
`timescale 1ns/100ps
module pci_tgt_top_bench;

  localparam int MEM_AW = 12;
  localparam int REG_AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              frame_n = 1'b1, irdy_n = 1'b1;
  logic [31:0]       ad = '0;
  logic [3:0]        cbe = 4'hF;
  logic [31:0]       ad_o;
  logic              ad_oe, devsel_n, trdy_n, stop_n;
  logic              mem_wr_o, mem_rd_req_o, reg_wr_o;
  logic [MEM_AW-3:0] mem_wr_addr_o, mem_rd_addr_o;
  logic [31:0]       mem_wr_data_o, reg_wr_data_o, reg_rd_data_i;
  logic [3:0]        mem_wr_be_o;
  logic              ack = 1'b0;
  logic [31:0]       rdat = '0;
  logic [REG_AW-3:0] reg_addr_o;
  logic              hold_ack = 1'b0;
  int                fetches = 0;
  int                cnt = 0;

  pci_tgt_top u_pci_tgt_top (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .irdy_ni(irdy_n),
    .ad_i(ad), .cbe_ni(cbe), .ad_o(ad_o), .ad_oe_o(ad_oe),
    .devsel_no(devsel_n), .trdy_no(trdy_n), .stop_no(stop_n),
    .mem_wr_o(mem_wr_o), .mem_wr_addr_o(mem_wr_addr_o), .mem_wr_data_o(mem_wr_data_o),
    .mem_wr_be_o(mem_wr_be_o), .mem_rd_req_o(mem_rd_req_o), .mem_rd_addr_o(mem_rd_addr_o),
    .mem_rd_ack_i(ack), .mem_rd_data_i(rdat), .reg_wr_o(reg_wr_o), .reg_addr_o(reg_addr_o),
    .reg_wr_data_o(reg_wr_data_o), .reg_rd_data_i(reg_rd_data_i)
  );

  function automatic logic [31:0] mem_val(logic [9:0] a);
    return {16'h5A5A, 6'h0, a};
  endfunction
  function automatic logic [31:0] reg_val(logic [5:0] a);
    return {16'hC0DE, 10'h0, a};
  endfunction

  assign reg_rd_data_i = reg_val(reg_addr_o);

  // local memory: acknowledge after a short latency unless held off
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0; cnt <= 0; fetches <= 0;
    end else begin
      ack <= 1'b0;
      if (mem_rd_req_o && ack) fetches <= fetches + 1;
      if (mem_rd_req_o && !ack && !hold_ack) begin
        if (cnt == 2) begin ack <= 1'b1; rdat <= mem_val(mem_rd_addr_o); cnt <= 0; end
        else cnt <= cnt + 1;
      end
    end
  end

  int checks = 0, fails = 0;
  int abort_bad = 0, hold_bad = 0;
  logic [63:0] wq[$];
  logic [31:0] rd_dat [0:7];
  int ndat;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // scoreboard monitor: every write strobe pops one expected item
  initial begin
    logic        p_req, p_ack;
    logic [9:0]  p_addr;
    logic [63:0] item, exp;
    p_req = 1'b0; p_ack = 1'b0; p_addr = '0;
    forever begin
      @(negedge clk);
      #1.5;
      if (rst_n) begin
        if (mem_wr_o || reg_wr_o) begin
          item = {15'd0, reg_wr_o, reg_wr_o ? 16'(reg_addr_o) : 16'(mem_wr_addr_o),
                  reg_wr_o ? reg_wr_data_o : mem_wr_data_o};
          if (wq.size() == 0) chk(1'b0, "R2 R3 unexpected write", item, 64'd0);
          else begin
            exp = wq.pop_front();
            chk(item == exp, "R2 R3 write item", item, exp);
          end
        end
        if (!stop_n && devsel_n) abort_bad++;
        if (p_req && !p_ack && (!mem_rd_req_o || mem_rd_addr_o != p_addr)) hold_bad++;
        p_req = mem_rd_req_o; p_ack = ack; p_addr = mem_rd_addr_o;
      end
    end
  end

  function automatic logic [63:0] wexp(logic isreg, logic [15:0] a, logic [31:0] d);
    return {15'd0, isreg, a, d};
  endfunction

  // term: 0 all phases done, 1 retry, 2 disconnect with data, 3 unclaimed
  task automatic xact(input logic [31:0] a, input logic [3:0] cmd, input logic [3:0] be_n,
                      input logic [31:0] wd, input int nph, output int term);
    int  k, wc;
    logic done;
    term = 0; ndat = 0; k = 0; wc = 0; done = 1'b0;
    @(negedge clk); frame_n = 1'b0; irdy_n = 1'b1; ad = a; cbe = cmd;
    @(negedge clk); cbe = be_n; ad = wd; irdy_n = 1'b0; frame_n = (nph == 1);
    while (!done) begin
      #1;
      if (devsel_n) begin
        wc++;
        if (wc > 4) begin term = 3; done = 1'b1; end
        else @(negedge clk);
      end else if (!trdy_n) begin
        rd_dat[ndat] = ad_o; ndat++; k++;
        if (!stop_n) begin
          term = 2;
          if (!frame_n) begin @(negedge clk); frame_n = 1'b1; end
          @(negedge clk); done = 1'b1;
        end else if (k == nph) begin
          @(negedge clk); done = 1'b1;
        end else begin
          @(negedge clk); ad = wd + k; frame_n = (k == nph - 1);
        end
      end else if (!stop_n) begin
        term = 1;
        if (!frame_n) begin @(negedge clk); frame_n = 1'b1; end
        @(negedge clk); done = 1'b1;
      end else @(negedge clk);
    end
    frame_n = 1'b1; irdy_n = 1'b1; cbe = 4'hF; ad = '0;
    @(negedge clk);
  endtask

  localparam logic [31:0] A = 32'h1000_0040, B = 32'h1000_0080;
  localparam logic [31:0] C = 32'h1000_00C0, D = 32'h1000_0100;

  initial begin
    int t;
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    chk(devsel_n && trdy_n && stop_n, "R11 handshake idle", {devsel_n, trdy_n, stop_n}, 3'b111);
    chk(!ad_oe && !mem_wr_o && !reg_wr_o && !mem_rd_req_o, "R11 outputs low",
        {ad_oe, mem_wr_o, reg_wr_o, mem_rd_req_o}, 4'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 memory writes: full burst, each half, then an illegal byte write
    for (int i = 0; i < 3; i++) wq.push_back(wexp(1'b0, 16'h80 + 16'(i), 32'hAB00_0000 + i));
    xact(32'h1000_0200, 4'b0111, 4'b0000, 32'hAB00_0000, 3, t);
    chk(t == 0, "R2 burst zero wait", t, 0);
    wq.push_back(wexp(1'b0, 16'h90, 32'h1111_0000));
    xact(32'h1000_0240, 4'b0111, 4'b1100, 32'h1111_0000, 1, t);
    wq.push_back(wexp(1'b0, 16'h91, 32'h2222_0000));
    xact(32'h1000_0244, 4'b1111, 4'b0011, 32'h2222_0000, 1, t);
    xact(32'h1000_0248, 4'b0111, 4'b1110, 32'h3333_0000, 1, t);
    chk(t == 0, "R2 byte write completes silently", t, 0);

    // R3 register writes
    wq.push_back(wexp(1'b1, 16'h4, 32'hCAFE_0000));
    wq.push_back(wexp(1'b1, 16'h5, 32'hCAFE_0001));
    xact(32'h2000_0010, 4'b0111, 4'b0000, 32'hCAFE_0000, 2, t);
    chk(t == 0, "R3 full burst", t, 0);
    xact(32'h2000_0018, 4'b0111, 4'b0011, 32'hDEAD_0000, 1, t);
    chk(t == 0, "R3 half write completes without strobe", t, 0);
    repeat (2) @(negedge clk);
    chk(wq.size() == 0, "R2 R3 all writes seen", wq.size(), 0);

    // R4 register reads
    xact(32'h2000_0020, 4'b0110, 4'b0000, 32'h0, 3, t);
    chk(t == 0 && ndat == 3, "R4 burst read", ndat, 3);
    for (int i = 0; i < 3; i++)
      chk(rd_dat[i] == reg_val(6'(8 + i)), "R4 read data", rd_dat[i], reg_val(6'(8 + i)));
    xact(32'h2000_0024, 4'b0110, 4'b1100, 32'h0, 1, t);
    chk(rd_dat[0] == reg_val(6'd9), "R4 half read", rd_dat[0], reg_val(6'd9));
    xact(32'h2000_0024, 4'b0110, 4'b1110, 32'h0, 1, t);
    chk(t == 0 && rd_dat[0] == 32'h0, "R4 byte read returns zero", rd_dat[0], 32'h0);

    // R5 R6 delayed reads and matching
    xact(A, 4'b0110, 4'b0000, 32'h0, 1, t);
    chk(t == 1, "R5 first read retried", t, 1);
    repeat (12) @(negedge clk);
    chk(fetches == 1, "R5 one fetch", fetches, 1);
    xact(A, 4'b1100, 4'b0000, 32'h0, 2, t);
    chk(t == 1, "R6 command mismatch no data", t, 1);
    repeat (12) @(negedge clk);
    chk(fetches == 2, "R6 mismatch latched own slot", fetches, 2);
    xact(A, 4'b0110, 4'b1100, 32'h0, 1, t);
    chk(t == 1, "R6 enable mismatch no data", t, 1);
    repeat (12) @(negedge clk);
    chk(fetches == 2, "R7 full slots no latch", fetches, 2);
    xact(A, 4'b0110, 4'b0000, 32'h0, 2, t);
    chk(t == 2 && rd_dat[0] == mem_val(10'h10), "R6 delivery", rd_dat[0], mem_val(10'h10));
    xact(A, 4'b1100, 4'b0000, 32'h0, 1, t);
    chk(t == 2 && rd_dat[0] == mem_val(10'h10), "R6 second slot delivery", t, 2);
    xact(A, 4'b0110, 4'b0000, 32'h0, 1, t);
    chk(t == 1, "R6 slot freed after delivery", t, 1);
    repeat (12) @(negedge clk);
    xact(A, 4'b0110, 4'b0000, 32'h0, 1, t);
    chk(t == 2 && fetches == 3, "R6 refetch delivered", fetches, 3);

    // R7 R12 both slots busy with acknowledge held off
    hold_ack = 1'b1;
    xact(B, 4'b0110, 4'b0000, 32'h0, 1, t);
    repeat (4) @(negedge clk);
    xact(B, 4'b0110, 4'b0000, 32'h0, 1, t);
    #1;
    chk(t == 1 && fetches == 3 && mem_rd_req_o && mem_rd_addr_o == 10'h20,
        "R12 repeat of unfilled read", {t[3:0], mem_rd_req_o, mem_rd_addr_o}, {4'd1, 1'b1, 10'h20});
    xact(C, 4'b0110, 4'b0000, 32'h0, 1, t);
    xact(D, 4'b0110, 4'b0000, 32'h0, 1, t);
    chk(t == 1, "R7 third read retried", t, 1);
    hold_ack = 1'b0;
    repeat (25) @(negedge clk);
    chk(fetches == 5, "R7 only two fetched", fetches, 5);
    xact(B, 4'b0110, 4'b0000, 32'h0, 1, t);
    chk(t == 2 && rd_dat[0] == mem_val(10'h20), "R7 B delivered", rd_dat[0], mem_val(10'h20));
    xact(C, 4'b0110, 4'b0000, 32'h0, 1, t);
    chk(t == 2 && rd_dat[0] == mem_val(10'h30), "R7 C delivered", rd_dat[0], mem_val(10'h30));
    xact(D, 4'b0110, 4'b0000, 32'h0, 1, t);
    chk(t == 1, "R7 D latched only now", t, 1);
    repeat (12) @(negedge clk);
    xact(D, 4'b0110, 4'b0000, 32'h0, 1, t);
    chk(t == 2 && rd_dat[0] == mem_val(10'h40) && fetches == 6, "R7 D delivered",
        rd_dat[0], mem_val(10'h40));

    // R8 illegal memory read
    xact(B, 4'b0110, 4'b1110, 32'h0, 1, t);
    chk(t == 2 && rd_dat[0] == 32'h0, "R8 byte read zero disconnect", rd_dat[0], 32'h0);
    xact(B, 4'b0110, 4'b0000 ^ 4'b1111, 32'h0, 1, t);
    chk(t == 2 && rd_dat[0] == 32'h0, "R8 empty enables", t, 2);
    repeat (12) @(negedge clk);
    chk(fetches == 6, "R8 no fetch", fetches, 6);

    // R1 unclaimed cycles
    xact(32'h3000_0000, 4'b0110, 4'b0000, 32'h0, 1, t);
    chk(t == 3, "R1 outside windows", t, 3);
    xact(A, 4'b0010, 4'b0000, 32'h0, 1, t);
    chk(t == 3, "R1 non-memory command", t, 3);

    chk(abort_bad == 0, "R9 no target abort", abort_bad, 0);
    chk(hold_bad == 0, "R10 request held", hold_bad, 0);
    chk(wq.size() == 0, "R2 R3 queue drained", wq.size(), 0);
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

endmodule